// File: doc/BRIEF.md
# Packet FIFO with Replayable Reads

This block is a single-clock first-in first-out buffer with a valid/ready handshake on its write side and on its read side. Each stored word can carry an end-of-packet flag. In packet mode, a packet becomes visible to the reader only once its final word has been accepted. A packet that is still being written can be thrown away with a drop strobe.

The reader can also replay a packet. While the replay request is high, the words handed out stay in the buffer. After the flagged final word, reading starts again at the first word of the same packet. Reading it once more with the request low frees it. The block reports how many words it holds and raises an almost-full flag at a programmable threshold. An optional register stage on the read outputs improves timing, and selecting it turns replay off. The depth must be a power of two.

The defaults are 8-bit data, depth 8 and almost-full threshold 6, with flag storage, packet mode, drop and replay all on and the output register off. The requirements below assume these defaults.

Top module: `pkt_replay_fifo`

## Requirements
- R1: While and after reset, the buffer is empty: `rd_valid`=0, `wr_ready`=1, `level`=0 and `almost_full`=0.
- R2: Words read with `rd_peek`=0 come out in write order, each with the `wr_last` value it was written with, and each such read lowers `level` by one.
- R3: `level` counts accepted words that have not been freed. `wr_ready` is 0 exactly when `level` equals the depth, and a write offered while `wr_ready`=0 is not stored.
- R4: In packet mode, `rd_valid` stays 0 until a word written with `wr_last`=1 has been accepted, and it rises in the cycle after that write.
- R5: A `drop` pulse in any cycle removes every word accepted since the last accepted `wr_last` word, whatever `wr_valid` and `wr_ready` are. Those words are never read, and committed words are unaffected.
- R6: If `drop` is high in the same cycle as an accepted `wr_last` word, that whole packet, including this word, is removed.
- R7: A read with `rd_peek`=1 does not lower `level`. After the word flagged last is read this way, the next word presented is the first word of the same packet.
- R8: After replays, a pass with `rd_peek`=0 frees the packet, and the reader then moves on to the following packet.
- R9: `almost_full` is 1 exactly when `level` is at or above the threshold `AF_LEVEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Space available |
| wr_data | input | DATA_W | Write data |
| wr_last | input | 1 | Write word ends a packet |
| drop | input | 1 | Discard the packet in progress |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | DATA_W | Read data |
| rd_last | output | 1 | Read word ends a packet |
| rd_peek | input | 1 | Replay: read without freeing |
| level | output | $clog2(DEPTH)+1 | Words held |
| almost_full | output | 1 | Level at or above AF_LEVEL |

## Verification
Some properties are checked on every cycle: the level stays in range, a drop returns the write pointer to the commit point, a replay read leaves the level unchanged and jumps back to the packet start after the last word, and a freeing read lowers the level by one. Other behaviour can only be shown by the bench's scenarios. These are data order and flag return, rd_valid being held back until a packet is complete, drops at every position (including on the last word), refusal of writes when full, and moving on to the next packet after replays. The bench sweeps packet lengths from one word up to the full depth.

// File: rtl/pkt_replay_fifo_pkg.sv
`timescale 1ns/1ps
package pkt_replay_fifo_pkg;
  // Read-pointer action chosen each cycle
  typedef enum logic [1:0] {
    RD_HOLD   = 2'd0,
    RD_POP    = 2'd1,
    RD_STEP   = 2'd2,
    RD_REWIND = 2'd3
  } rd_op_e;
endpackage

// File: rtl/prf_store.sv
`timescale 1ns/1ps
module prf_store #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Storage array: no reset, write enable written out
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/prf_ptrs.sv
`timescale 1ns/1ps
module prf_ptrs
  import pkt_replay_fifo_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AF_LEVEL  = 6,
  parameter bit PACKET_ON = 1'b1,
  parameter bit DROP_ON   = 1'b1,
  parameter bit PEEK_ON   = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_last,
  input  logic              drop,
  input  logic              rd_take,
  input  logic              rd_peek,
  input  logic              rd_last_word,
  output logic              wr_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_avail,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  level,
  output logic              almost_full
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] AF_P    = PTR_W'(AF_LEVEL);

  logic [PTR_W-1:0] wr_q, wr_d;     // next write slot, includes uncommitted words
  logic [PTR_W-1:0] cm_q, cm_d;     // end of committed packets
  logic [PTR_W-1:0] rd_q, rd_d;     // next word presented to the reader
  logic [PTR_W-1:0] base_q, base_d; // first word not yet freed
  logic             drop_en, peek_en, rd_fire;
  rd_op_e           rd_op;

  assign drop_en = (PACKET_ON && DROP_ON) ? drop : 1'b0;
  assign peek_en = PEEK_ON ? rd_peek : 1'b0;

  assign level       = wr_q - base_q;
  assign wr_ready    = (level != DEPTH_P);
  assign wr_en       = wr_valid & wr_ready;
  assign almost_full = (level >= AF_P);
  assign rd_avail    = PACKET_ON ? (rd_q != cm_q) : (rd_q != wr_q);
  assign rd_fire     = rd_take & rd_avail;
  assign wr_addr     = wr_q[ADDR_W-1:0];
  assign rd_addr     = rd_q[ADDR_W-1:0];

  // Write side next state
  always_comb begin
    wr_d = wr_q;
    cm_d = cm_q;
    if (wr_en) begin
      wr_d = wr_q + 1'b1;
    end
    if (PACKET_ON) begin
      if (wr_en && wr_last && !drop_en) begin
        cm_d = wr_q + 1'b1;
      end
      if (drop_en) begin
        wr_d = cm_q;
      end
    end else begin
      cm_d = wr_d;
    end
  end

  // Read side action select
  always_comb begin
    rd_op = RD_HOLD;
    if (rd_fire) begin
      if (!peek_en)          rd_op = RD_POP;
      else if (rd_last_word) rd_op = RD_REWIND;
      else                   rd_op = RD_STEP;
    end
  end

  // Read side next state
  always_comb begin
    rd_d   = rd_q;
    base_d = base_q;
    unique case (rd_op)
      RD_POP: begin
        rd_d   = rd_q + 1'b1;
        base_d = rd_q + 1'b1;
      end
      RD_STEP:   rd_d = rd_q + 1'b1;
      RD_REWIND: rd_d = base_q;
      default:   rd_d = rd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      cm_q   <= '0;
      rd_q   <= '0;
      base_q <= '0;
    end else begin
      wr_q   <= wr_d;
      cm_q   <= cm_d;
      rd_q   <= rd_d;
      base_q <= base_d;
    end
  end

  // R3: the held count never exceeds the depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_P);

  // R3: with no room and no read or drop, the count is frozen
  a_r3_full_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !rd_fire && !drop_en) |=> (level == $past(level)));

  // R5: a drop leaves the write pointer at the commit point
  a_r5_drop_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |=> (wr_q == cm_q));

  // R7: a replay read frees nothing
  a_r7_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && peek_en && !wr_en && !drop_en) |=> (level == $past(level)));

  // R7: a replay read of the last word returns to the packet start
  a_r7_peek_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && peek_en && rd_last_word) |=> (rd_q == base_q));

  // R2: a freeing read alone lowers the count by one
  a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !peek_en && !wr_en && !drop_en) |=> (PTR_W'(level + 1'b1) == $past(level)));
endmodule

// File: rtl/prf_outreg.sv
`timescale 1ns/1ps
module prf_outreg #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic              v_q;
  logic [WORD_W-1:0] w_q;
  logic              load;

  assign in_ready  = !v_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = v_q;
  assign out_word  = w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else if (in_ready) begin
      v_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      w_q <= in_word;
    end
  end
endmodule

// File: rtl/pkt_replay_fifo.sv
`timescale 1ns/1ps
module pkt_replay_fifo #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int AF_LEVEL  = 6,
  parameter bit EN_LAST   = 1'b1,
  parameter bit EN_PACKET = 1'b1,
  parameter bit EN_DROP   = 1'b1,
  parameter bit EN_PEEK   = 1'b1,
  parameter bit EN_OUTREG = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_last,
  input  logic                   drop,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_last,
  input  logic                   rd_peek,
  output logic [$clog2(DEPTH):0] level,
  output logic                   almost_full
);
  localparam int  ADDR_W  = $clog2(DEPTH);
  localparam int  WORD_W  = DATA_W + (EN_LAST ? 1 : 0);
  localparam bit  PEEK_ON = EN_PEEK && EN_LAST && !EN_OUTREG;

  logic              wr_en, core_avail, core_take, core_last;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0] store_in, store_out;

  generate
    if (EN_LAST) begin : g_flag
      assign store_in  = {wr_last, wr_data};
      assign core_last = store_out[DATA_W];
    end else begin : g_noflag
      assign store_in  = wr_data;
      assign core_last = 1'b0;
    end
  endgenerate

  prf_ptrs #(
    .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .PACKET_ON(EN_PACKET),
    .DROP_ON(EN_DROP), .PEEK_ON(PEEK_ON)
  ) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
    .drop(drop), .rd_take(core_take), .rd_peek(rd_peek),
    .rd_last_word(core_last), .wr_ready(wr_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_avail(core_avail), .rd_addr(rd_addr),
    .level(level), .almost_full(almost_full)
  );

  prf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(store_in),
    .raddr(rd_addr), .rdata(store_out)
  );

  generate
    if (EN_OUTREG) begin : g_reg
      logic [WORD_W-1:0] out_word;
      prf_outreg #(.WORD_W(WORD_W)) u_oreg (
        .clk(clk), .rst_n(rst_n), .in_valid(core_avail), .in_ready(core_take),
        .in_word(store_out), .out_valid(rd_valid), .out_ready(rd_ready),
        .out_word(out_word)
      );
      assign rd_data = out_word[DATA_W-1:0];
      if (EN_LAST) begin : g_rl
        assign rd_last = out_word[DATA_W];
      end else begin : g_nrl
        assign rd_last = 1'b0;
      end
    end else begin : g_direct
      assign rd_valid  = core_avail;
      assign core_take = rd_ready;
      assign rd_data   = store_out[DATA_W-1:0];
      assign rd_last   = core_last;
    end
  endgenerate

  // R9: the flag only rises once the count has reached the threshold
  a_r9_af_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(almost_full) |-> (level >= ($clog2(DEPTH)+1)'(AF_LEVEL)));
endmodule

// File: tb/tb_pkt_replay_fifo.sv
`timescale 1ns/1ps
module tb_pkt_replay_fifo;
  localparam int DW = 8;
  localparam int DP = 8;
  localparam int AF = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid, wr_last, drop, rd_ready, rd_peek;
  logic [DW-1:0] wr_data;
  logic          wr_ready, rd_valid, rd_last, almost_full;
  logic [DW-1:0] rd_data;
  logic [3:0]    level;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  pkt_replay_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .drop(drop), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .rd_peek(rd_peek), .level(level), .almost_full(almost_full)
  );

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] d, input logic l, input logic dr);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_last = l; drop = dr;
    @(posedge clk); #1;
    wr_valid = 1'b0; wr_last = 1'b0; drop = 1'b0;
  endtask

  task automatic drop_only();
    @(negedge clk);
    drop = 1'b1;
    @(posedge clk); #1;
    drop = 1'b0;
  endtask

  task automatic rd_word(input logic pk, input int exp_d, input int exp_l, input string req);
    @(negedge clk);
    rd_ready = 1'b1; rd_peek = pk;
    #1;
    chk(req, "rd_valid", int'(rd_valid), 1);
    chk(req, "rd_data", int'(rd_data), exp_d);
    chk(req, "rd_last", int'(rd_last), exp_l);
    @(posedge clk); #1;
    rd_ready = 1'b0; rd_peek = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_last = 1'b0; drop = 1'b0;
    rd_ready = 1'b0; rd_peek = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rd_valid in reset", int'(rd_valid), 0);
    chk("R1", "wr_ready in reset", int'(wr_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "wr_ready", int'(wr_ready), 1);
    chk("R1", "level", int'(level), 0);
    chk("R1", "almost_full", int'(almost_full), 0);

    // Sweep of packet lengths 1..DP: fill, replay twice, free
    for (int n = 1; n <= DP; n++) begin
      for (int i = 0; i < n; i++) begin
        wr_word(DW'(n*16 + i), (i == n-1), 1'b0);
        chk("R3", "level after write", int'(level), i+1);
        chk("R9", "almost_full", int'(almost_full), int'(i+1 >= AF));
        if (i < n-1) chk("R4", "rd_valid before last", int'(rd_valid), 0);
        else         chk("R4", "rd_valid after last", int'(rd_valid), 1);
      end
      chk("R3", "wr_ready", int'(wr_ready), int'(n < DP));
      if (n == DP) begin
        wr_word(8'hEE, 1'b1, 1'b0);
        chk("R3", "level after refused write", int'(level), DP);
      end
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < n; i++) rd_word(1'b1, n*16 + i, int'(i == n-1), "R7");
        chk("R7", "level after replay", int'(level), n);
      end
      for (int i = 0; i < n; i++) begin
        rd_word(1'b0, n*16 + i, int'(i == n-1), "R2");
        chk("R2", "level after pop", int'(level), n-1-i);
      end
      chk("R2", "rd_valid when drained", int'(rd_valid), 0);
      chk("R9", "almost_full drained", int'(almost_full), 0);
    end

    // R8: replay first packet, free it, then the second follows
    wr_word(8'hA0, 1'b0, 1'b0); wr_word(8'hA1, 1'b0, 1'b0); wr_word(8'hA2, 1'b1, 1'b0);
    wr_word(8'hB0, 1'b0, 1'b0); wr_word(8'hB1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) rd_word(1'b1, 'hA0 + i, int'(i == 2), "R7");
    for (int i = 0; i < 3; i++) rd_word(1'b0, 'hA0 + i, int'(i == 2), "R8");
    chk("R8", "level after freeing first", int'(level), 2);
    rd_word(1'b1, 'hB0, 0, "R8"); rd_word(1'b1, 'hB1, 1, "R8");
    rd_word(1'b0, 'hB0, 0, "R8"); rd_word(1'b0, 'hB1, 1, "R8");
    chk("R8", "empty at end", int'(rd_valid), 0);

    // R5 / R6: drops at several positions
    wr_word(8'h50, 1'b0, 1'b0); wr_word(8'h51, 1'b1, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      for (int i = 0; i < k; i++) wr_word(DW'('hD0 + i), 1'b0, 1'b0);
      chk("R5", "level before drop", int'(level), 2 + k);
      drop_only();
      chk("R5", "level after drop", int'(level), 2);
      #1 chk("R5", "committed head kept", int'(rd_data), 'h50);
    end
    wr_word(8'hDD, 1'b0, 1'b1);
    chk("R5", "drop with write", int'(level), 2);
    drop_only();
    chk("R5", "drop with nothing pending", int'(level), 2);
    wr_word(8'hC0, 1'b0, 1'b0); wr_word(8'hC1, 1'b1, 1'b1);
    chk("R6", "drop on last word", int'(level), 2);
    rd_word(1'b0, 'h50, 0, "R6"); rd_word(1'b0, 'h51, 1, "R6");
    chk("R6", "dropped packet unseen", int'(rd_valid), 0);
    chk("R6", "level empty", int'(level), 0);
    wr_word(8'h70, 1'b1, 1'b0);
    rd_word(1'b0, 'h70, 1, "R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule